// File: doc/BRIEF.md
# Segmented Comparand Rotate Register

This block holds the search key that a content-addressable match array compares against every stored entry. The key is 64 bits wide. A host loads it, and reads it back, through a 16-bit data port. One quarter of the word is reachable at a time, and an internal segment pointer selects that quarter. After each access the pointer steps to the next quarter. The host can also set the pointer directly, so a full key is written with four consecutive strobes.

The key splits into two fields. The upper part, from bit 63 down to a programmable boundary `camLow`, is the compare field. The bits below the boundary are the data field. On command, the compare field rotates by one bit in either direction and wraps within its own limits. The data field stays as it is during a rotate. The complete 64-bit word is always driven out to the match array.

Top module: `seg_comparand`

## Requirements
- R1: While `rstN` is low, `comparand` is all zeros and `segPtr` is 0.
- R2: A cycle with `wrEn` high loads `dataIn` into segment `segPtr`, which is bits 16k+15 down to 16k for k = `segPtr`. The other three segments keep their values.
- R3: `dataOut` always shows segment `segPtr` of the current `comparand`. It follows the pointer combinationally.
- R4: A cycle with `wrEn` or `rdEn` high (either or both) advances `segPtr` by exactly one, and it wraps from 3 to 0.
- R5: A cycle with `segLoad` high sets `segPtr` to `segValue`. This overrides any advance in the same cycle.
- R6: `shiftRight` alone, without a write, moves each bit i in the field [63:`camLow`] to bit i-1. The old bit `camLow` enters at bit 63.
- R7: `shiftLeft` alone, without a write, moves each bit i in the field [63:`camLow`] to bit i+1. The old bit 63 enters at bit `camLow`.
- R8: During a rotate, bits below `camLow` are unchanged. With `camLow` = 0 the whole word rotates, and with `camLow` = 63 a rotate leaves the word unchanged.
- R9: When `wrEn` is high in the same cycle as a shift command, only the write takes effect and the shift is ignored.
- R10: When both shift commands are high, or no write or shift is requested, `comparand` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the selected segment |
| rdEn | input | 1 | Read strobe; advances the pointer |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Selected segment of the register |
| segLoad | input | 1 | Load the segment pointer directly |
| segValue | input | 2 | Pointer value for `segLoad` |
| shiftRight | input | 1 | Rotate the compare field toward the LSB |
| shiftLeft | input | 1 | Rotate the compare field toward the MSB |
| camLow | input | 6 | Lowest bit index of the compare field |
| segPtr | output | 2 | Current segment pointer |
| comparand | output | 64 | Full key driven to the match array |

## Verification
The hardest cases to reach from the ports are rotates at the extreme boundaries, and the collisions of a write with a shift or of a load with an advance. Random stimulus only rarely produces those exact pairings while the register holds a pattern that would reveal a wrong wrap. The bench therefore first loads asymmetric patterns through the segment port. It then directs single-bit-field rotates (`camLow` = 63), full-word rotates (`camLow` = 0), mid-word boundaries, simultaneous write-and-shift, and both-shift cycles. After that, a seeded random phase mixes every strobe and boundary value against a model in the bench.

// File: rtl/seg_comparand_pkg.sv
package seg_comparand_pkg;
  localparam int WORD_W = 64;
  localparam int SEG_W  = 16;

  typedef struct packed {
    logic wrStb;
    logic rotRight;
    logic rotLeft;
  } cmd_t;
endpackage

// File: rtl/seg_comparand_ctrl.sv
module seg_comparand_ctrl #(
  parameter int SEG_N = 4,
  localparam int PTR_W = $clog2(SEG_N)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic segLoad,
  input  logic [PTR_W-1:0] segValue,
  input  logic shiftRight,
  input  logic shiftLeft,
  output logic [PTR_W-1:0] ptr,
  output seg_comparand_pkg::cmd_t cmd
);
  logic [PTR_W-1:0] ptrNext;

  always_comb begin
    ptrNext = ptr;
    if (segLoad) ptrNext = segValue;
    else if (wrEn || rdEn) begin
      if (ptr == PTR_W'(SEG_N - 1)) ptrNext = '0;
      else ptrNext = ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else ptr <= ptrNext;
  end

  // write wins over shift; opposing shifts cancel
  always_comb begin
    cmd.wrStb    = wrEn;
    cmd.rotRight = !wrEn && shiftRight && !shiftLeft;
    cmd.rotLeft  = !wrEn && shiftLeft && !shiftRight;
  end
endmodule

// File: rtl/seg_comparand_dp.sv
module seg_comparand_dp #(
  parameter int WORD_W = 64,
  parameter int SEG_W = 16,
  localparam int SEG_N = WORD_W / SEG_W,
  localparam int PTR_W = $clog2(SEG_N),
  localparam int BND_W = $clog2(WORD_W)
) (
  input  logic clk,
  input  logic rstN,
  input  seg_comparand_pkg::cmd_t cmd,
  input  logic [PTR_W-1:0] ptr,
  input  logic [SEG_W-1:0] dataIn,
  input  logic [BND_W-1:0] camLow,
  output logic [SEG_W-1:0] dataOut,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] rotR, rotL, nextWord;
  logic [SEG_W-1:0] segView [SEG_N];
  logic lowBit;

  assign lowBit = word[camLow];

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == WORD_W - 1) begin : g_top
      assign rotR[i] = (BND_W'(i) < camLow) ? word[i] : lowBit;
      assign rotL[i] = (BND_W'(i) == camLow) ? word[WORD_W-1] : word[i-1];
    end else if (i == 0) begin : g_bot
      assign rotR[i] = (camLow == '0) ? word[i+1] : word[i];
      assign rotL[i] = (camLow == '0) ? word[WORD_W-1] : word[i];
    end else begin : g_mid
      assign rotR[i] = (BND_W'(i) < camLow) ? word[i] : word[i+1];
      assign rotL[i] = (BND_W'(i) < camLow)  ? word[i] :
                       (BND_W'(i) == camLow) ? word[WORD_W-1] : word[i-1];
    end
  end

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign segView[k] = word[k*SEG_W +: SEG_W];
    always_comb begin
      if (cmd.wrStb && ptr == PTR_W'(k)) nextWord[k*SEG_W +: SEG_W] = dataIn;
      else if (cmd.rotRight)             nextWord[k*SEG_W +: SEG_W] = rotR[k*SEG_W +: SEG_W];
      else if (cmd.rotLeft)              nextWord[k*SEG_W +: SEG_W] = rotL[k*SEG_W +: SEG_W];
      else                               nextWord[k*SEG_W +: SEG_W] = word[k*SEG_W +: SEG_W];
    end
  end

  assign dataOut = segView[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) word <= '0;
    else word <= nextWord;
  end
endmodule

// File: rtl/seg_comparand.sv
module seg_comparand #(
  parameter int WORD_W = seg_comparand_pkg::WORD_W,
  parameter int SEG_W = seg_comparand_pkg::SEG_W,
  localparam int SEG_N = WORD_W / SEG_W,
  localparam int PTR_W = $clog2(SEG_N),
  localparam int BND_W = $clog2(WORD_W)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [SEG_W-1:0] dataIn,
  output logic [SEG_W-1:0] dataOut,
  input  logic segLoad,
  input  logic [PTR_W-1:0] segValue,
  input  logic shiftRight,
  input  logic shiftLeft,
  input  logic [BND_W-1:0] camLow,
  output logic [PTR_W-1:0] segPtr,
  output logic [WORD_W-1:0] comparand
);
  seg_comparand_pkg::cmd_t cmd;

  seg_comparand_ctrl #(.SEG_N(SEG_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .segLoad(segLoad), .segValue(segValue),
    .shiftRight(shiftRight), .shiftLeft(shiftLeft),
    .ptr(segPtr), .cmd(cmd)
  );

  seg_comparand_dp #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ptr(segPtr), .dataIn(dataIn),
    .camLow(camLow), .dataOut(dataOut), .word(comparand)
  );
endmodule

// File: rtl/seg_comparand_checker.sv
module seg_comparand_checker #(
  parameter int WORD_W = 64,
  parameter int SEG_W = 16,
  localparam int SEG_N = WORD_W / SEG_W,
  localparam int PTR_W = $clog2(SEG_N),
  localparam int BND_W = $clog2(WORD_W)
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic rdEn,
  input logic [SEG_W-1:0] dataIn,
  input logic [SEG_W-1:0] dataOut,
  input logic segLoad,
  input logic [PTR_W-1:0] segValue,
  input logic shiftRight,
  input logic shiftLeft,
  input logic [BND_W-1:0] camLow,
  input logic [PTR_W-1:0] segPtr,
  input logic [WORD_W-1:0] comparand
);
  logic [WORD_W-1:0] lowMask;
  logic anyShift;
  assign lowMask = (WORD_W'(1) << camLow) - WORD_W'(1);
  assign anyShift = shiftRight ^ shiftLeft;

  for (genvar k = 0; k < SEG_N; k++) begin : g_wr
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && segPtr == PTR_W'(k)) |=> comparand[k*SEG_W +: SEG_W] == $past(dataIn));
  end

  a_r4_advance: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || rdEn) && !segLoad) |=> segPtr == PTR_W'($past(segPtr) + PTR_W'(1)));

  a_r5_load: assert property (@(posedge clk) disable iff (!rstN)
    segLoad |=> segPtr == $past(segValue));

  a_r6_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rstN)
    (anyShift && !wrEn) |=> $countones(comparand) == $countones($past(comparand)));

  a_r8_low_field_kept: assert property (@(posedge clk) disable iff (!rstN)
    (anyShift && !wrEn) |=> (comparand & $past(lowMask)) == $past(comparand & lowMask));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !anyShift) |=> $stable(comparand));
endmodule

bind seg_comparand seg_comparand_checker #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/seg_comparand_bench.sv
module seg_comparand_bench;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0, segLoad = 0, shiftRight = 0, shiftLeft = 0;
  logic [15:0] dataIn = '0;
  logic [1:0] segValue = '0;
  logic [5:0] camLow = '0;
  logic [15:0] dataOut;
  logic [1:0] segPtr;
  logic [63:0] comparand;

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] expCmp = '0;
  logic [1:0] expPtr = '0;

  always #10 clk = ~clk;

  seg_comparand u_seg_comparand (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [63:0] modelRotRight(logic [63:0] v, int low);
    logic [63:0] r = v;
    for (int i = low; i < 63; i++) r[i] = v[i+1];
    r[63] = v[low];
    return r;
  endfunction

  function automatic logic [63:0] modelRotLeft(logic [63:0] v, int low);
    logic [63:0] r = v;
    for (int i = low + 1; i <= 63; i++) r[i] = v[i-1];
    r[low] = v[63];
    return r;
  endfunction

  task automatic check64(logic ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: inputs driven at negedge, outputs checked at next negedge
  task automatic step(logic w, logic r, logic ld, logic [1:0] lv, logic sr, logic sl,
                      logic [15:0] d, logic [5:0] low);
    string tag;
    wrEn = w; rdEn = r; segLoad = ld; segValue = lv;
    shiftRight = sr; shiftLeft = sl; dataIn = d; camLow = low;
    #1;
    check64(dataOut == expCmp[expPtr*16 +: 16], "R3 dataOut", 64'(dataOut), 64'(expCmp[expPtr*16 +: 16]));
    if (w) begin
      expCmp[expPtr*16 +: 16] = d;
      tag = (sr || sl) ? "R9 write over shift" : "R2 write";
    end else if (sr && !sl) begin
      expCmp = modelRotRight(expCmp, int'(low));
      tag = (low == 0 || low == 63) ? "R8 rotate right edge" : "R6 rotate right";
    end else if (sl && !sr) begin
      expCmp = modelRotLeft(expCmp, int'(low));
      tag = (low == 0 || low == 63) ? "R8 rotate left edge" : "R7 rotate left";
    end else tag = "R10 hold";
    if (ld) expPtr = lv;
    else if (w || r) expPtr = expPtr + 2'd1;
    @(negedge clk);
    check64(comparand == expCmp, tag, comparand, expCmp);
    check64(segPtr == expPtr, ld ? "R5 pointer load" : "R4 pointer advance",
            64'(segPtr), 64'(expPtr));
  endtask

  initial begin
    process::self().srandom(32'd1234);
    #3;
    check64(comparand == '0, "R1 reset word", comparand, '0);
    check64(segPtr == '0, "R1 reset pointer", 64'(segPtr), '0);
    @(negedge clk); @(negedge clk);
    rstN = 1;
    // directed: load four segments in order
    step(1,0,0,0,0,0,16'h8001,0);
    step(1,0,0,0,0,0,16'h1234,0);
    step(1,0,0,0,0,0,16'h00F0,0);
    step(1,0,0,0,0,0,16'hC003,0);
    // read back all four, pointer wrap
    for (int k = 0; k < 4; k++) step(0,1,0,0,0,0,0,0);
    // full-word rotates
    step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0,0);
    // single-bit field
    step(0,0,0,0,1,0,0,63);
    step(0,0,0,0,0,1,0,63);
    // mid boundaries
    step(0,0,0,0,1,0,0,48);
    step(0,0,0,0,0,1,0,17);
    step(0,0,0,0,0,1,0,62);
    // both shifts and idle
    step(0,0,0,0,1,1,0,5);
    step(0,0,0,0,0,0,0,5);
    // write with shift, load overriding advance
    step(1,0,0,0,1,0,16'hBEEF,10);
    step(1,1,1,2'd2,0,1,16'h5A5A,30);
    step(0,1,1,2'd0,0,0,0,0);
    // reset mid-run
    rstN = 0; #1;
    check64(comparand == '0, "R1 async reset word", comparand, '0);
    check64(segPtr == '0, "R1 async reset pointer", 64'(segPtr), '0);
    expCmp = '0; expPtr = '0;
    @(negedge clk); rstN = 1;
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int p = $urandom_range(0, 9);
      logic [5:0] low = ($urandom_range(0, 3) == 0) ? 6'(($urandom_range(0,1)) * 63) : 6'($urandom);
      step(p < 3, p == 3 || ($urandom_range(0,5) == 0), $urandom_range(0,7) == 0,
           2'($urandom), p >= 4 && p < 7 || p == 9, p >= 6 || p == 1,
           16'($urandom), low);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule